// File: doc/BRIEF.md
# Quadrant Memory Strobe Controller

This block sits between an address mapper and the external memory devices. It takes a 20-bit physical address together with a read or write request. The two top address bits pick one of four control registers, one for each 256K quadrant. That register decides which chip select goes low and which of two output-enable/write-enable pairs is driven. It also sets whether the write strobe is suppressed, whether the top two address lines are flipped on the way out, and how many wait states stretch the access.

A separate mode register flips chosen address lines only for data-space accesses. The same register can also hold chip select 1 low at all times. Each access runs a down-counter. The counter is loaded with the base length for the access (two cycles for a read, three for a write) plus the quadrant's wait states. The strobes are held low for the whole window and released on the last cycle, and a one-cycle done pulse marks that same cycle. A new request is taken only while the block reports ready.

Top module: `mbc_top`

## Requirements
- R1: The quadrant register is chosen by the incoming req_addr[19:18], before any inversion is applied, so an inverted output address never changes which register governs the access.
- R2: Control bits [1:0] pick the chip select: value k in 0..2 drives cs_n[k] low during the strobe window, and value 3 drives no chip select. One chip select may serve several quadrants.
- R3: Control bit 2 picks the strobe pair p. A read drives oe_n[p] low and a write drives we_n[p] low during the strobe window. An output enable and a write enable are never low together.
- R4: Control bit 3 set keeps both we_n lines high for a write in that quadrant. The chip select still goes low and the cycle length is unchanged.
- R5: Control bit 5 flips mem_addr[19] and control bit 4 flips mem_addr[18] for accesses in that quadrant only.
- R6: Control bits [7:6] give the wait states: 00 gives four, 01 gives two, 10 gives one and 11 gives zero. From the accepting clock edge to the done cycle an access takes 2 + waits cycles for a read and 3 + waits cycles for a write.
- R7: After reset, every control register and the mode register are zero, all strobes are high, done is low, ready is high and mem_addr is zero. The registers are write-only; cfg_addr 0..3 selects a quadrant register.
- R8: The mode register is at cfg_addr 4. Its bit 0 flips mem_addr[16] and its bit 1 flips mem_addr[19] when req_dspace is high. Instruction-space accesses (req_dspace low) are untouched.
- R9: With mode bit 4 set, cs_n[1] is low at all times, including when the block is idle.
- R10: The strobes are low from the cycle after acceptance up to the final cycle. On the final cycle they are all high and done is high for exactly that one cycle. mem_addr stays stable through the access.
- R11: A request is accepted only while ready is high. A request raised during an access is ignored and changes neither its length nor mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0..3 quadrant, 4 mode |
| cfg_data | input | 8 | Register write data |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dspace | input | 1 | 1 = data-space access |
| req_addr | input | 20 | Physical address |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle end-of-access pulse |
| cs_n | output | 3 | Chip selects, active low |
| oe_n | output | 2 | Output enables, active low |
| we_n | output | 2 | Write enables, active low |
| mem_addr | output | 20 | Address driven to memory |

## Verification
The accepting edge is the rising edge where req_valid meets ready. Strobes and mem_addr are due one cycle after that edge. The bench drives on falling edges and samples strobes and address at the first falling edge after the accepting edge. From there it counts falling edges until done is seen. That count must equal the base length plus the wait states. The strobes are sampled again in the done cycle, where they must already be high. Register writes take effect on the edge that captures them, so each access starts only after its configuration writes have completed.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam int CNT_W  = 3;
  localparam int CFG_AW = 3;

  typedef struct packed {
    logic [1:0] wait_code;
    logic       inv_a19;
    logic       inv_a18;
    logic       wr_inhibit;
    logic       pair_sel;
    logic [1:0] cs_sel;
  } bank_cfg_t;

  typedef struct packed {
    logic [2:0] rsvd_hi;
    logic       force_cs1;
    logic [1:0] rsvd_lo;
    logic       dinv_a19;
    logic       dinv_a16;
  } mode_cfg_t;

  function automatic logic [CNT_W-1:0] wait_cycles(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(1);
      default: return CNT_W'(0);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] access_len(input logic [1:0] code,
                                                  input logic       is_write);
    logic [CNT_W-1:0] base;
    base = is_write ? CNT_W'(3) : CNT_W'(2);
    return base + wait_cycles(code);
  endfunction

endpackage

// File: rtl/mbc_cfg_regs.sv
module mbc_cfg_regs
  import mbc_pkg::*;
#(
  parameter int N_BANKS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [7:0]                     cfg_data,
  output bank_cfg_t [N_BANKS-1:0]        banks_o,
  output mode_cfg_t                      mode_o
);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = cfg_wr && (cfg_addr == CFG_AW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   banks_o[b] <= '0;
      else if (hit) banks_o[b] <= bank_cfg_t'(cfg_data);
    end
  end

  logic mode_hit;
  assign mode_hit = cfg_wr && (cfg_addr == CFG_AW'(N_BANKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_o <= '0;
    else if (mode_hit) mode_o <= mode_cfg_t'(cfg_data);
  end

endmodule

// File: rtl/mbc_xlate.sv
module mbc_xlate
  import mbc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int N_BANKS = 4
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     dspace_i,
  input  bank_cfg_t [N_BANKS-1:0]  banks_i,
  input  mode_cfg_t                mode_i,
  output bank_cfg_t                sel_cfg_o,
  output logic [ADDR_W-1:0]        phys_o
);

  localparam int SEL_W = $clog2(N_BANKS);

  logic [SEL_W-1:0]  bank_idx;
  logic [ADDR_W-1:0] flip_mask;

  assign bank_idx  = addr_i[ADDR_W-1 -: SEL_W];
  assign sel_cfg_o = banks_i[bank_idx];

  always_comb begin
    flip_mask = '0;
    flip_mask[ADDR_W-1] = sel_cfg_o.inv_a19 ^ (dspace_i & mode_i.dinv_a19);
    flip_mask[ADDR_W-2] = sel_cfg_o.inv_a18;
    flip_mask[ADDR_W-4] = dspace_i & mode_i.dinv_a16;
  end

  assign phys_o = addr_i ^ flip_mask;

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             ready_o,
  output logic             active_o,
  output logic             strobe_win_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt      <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt      <= len_i;
    end else if (active_o) begin
      if (cnt == CNT_W'(1)) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign ready_o      = !active_o;
  assign last_o       = active_o && (cnt == CNT_W'(1));
  assign strobe_win_o = active_o && (cnt != CNT_W'(1));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);

  // R6: an accepted access is never shorter than a read
  a_r6_len_min: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (len_i >= CNT_W'(2)));

  // R11: no start while an access runs
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !start_i);

  // R10: an active access always has cycles left
  a_r10_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (cnt != '0));

endmodule

// File: rtl/mbc_top.sv
module mbc_top
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int N_CS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dspace,
  input  logic [19:0]       req_addr,
  output logic              ready,
  output logic              done,
  output logic [2:0]        cs_n,
  output logic [1:0]        oe_n,
  output logic [1:0]        we_n,
  output logic [19:0]       mem_addr
);

  localparam int N_BANKS = 4;
  localparam int N_PAIRS = 2;

  bank_cfg_t [N_BANKS-1:0] banks;
  mode_cfg_t               mode;
  bank_cfg_t               sel_cfg;
  logic [ADDR_W-1:0]       phys;

  bank_cfg_t         lat_cfg;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;

  logic start, active, strobe_win, last;

  mbc_cfg_regs #(.N_BANKS(N_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .banks_o  (banks),
    .mode_o   (mode)
  );

  mbc_xlate #(.ADDR_W(ADDR_W), .N_BANKS(N_BANKS)) u_xlate (
    .addr_i    (req_addr),
    .dspace_i  (req_dspace),
    .banks_i   (banks),
    .mode_i    (mode),
    .sel_cfg_o (sel_cfg),
    .phys_o    (phys)
  );

  assign start = req_valid && ready;

  mbc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .len_i        (access_len(sel_cfg.wait_code, req_write)),
    .ready_o      (ready),
    .active_o     (active),
    .strobe_win_o (strobe_win),
    .last_o       (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cfg   <= '0;
      lat_write <= 1'b0;
      lat_addr  <= '0;
    end else if (start) begin
      lat_cfg   <= sel_cfg;
      lat_write <= req_write;
      lat_addr  <= phys;
    end
  end

  assign done     = last;
  assign mem_addr = lat_addr;

  for (genvar c = 0; c < N_CS; c++) begin : g_cs
    logic hit;
    assign hit = strobe_win && (32'(lat_cfg.cs_sel) == c);
    if (c == 1) begin : g_force
      assign cs_n[c] = !(hit || mode.force_cs1);
    end else begin : g_plain
      assign cs_n[c] = !hit;
    end
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    logic pick;
    assign pick    = strobe_win && (32'(lat_cfg.pair_sel) == p);
    assign oe_n[p] = !(pick && !lat_write);
    assign we_n[p] = !(pick && lat_write && !lat_cfg.wr_inhibit);
  end

  // R3: read and write strobes never overlap
  a_r3_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((oe_n != 2'b11) && (we_n != 2'b11)));

  // R2: without the force option at most one chip select is low
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.force_cs1 |-> $onehot0(~cs_n));

  // R9: forced chip select 1 stays low
  a_r9_force_cs1: assert property (@(posedge clk) disable iff (!rst_n)
    mode.force_cs1 |-> !cs_n[1]);

  // R10: strobes idle on the final cycle and when no access runs
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || done) |-> ((oe_n == 2'b11) && (we_n == 2'b11)));

  // R10: address holds through the access
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> $stable(mem_addr));

  // R4: inhibited quadrant never pulses a write enable
  a_r4_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (active && lat_cfg.wr_inhibit) |-> (we_n == 2'b11));

endmodule

// File: tb/mbc_top_bench.sv
module mbc_top_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  bcfg;
    logic [7:0]  mode;
    logic        wr;
    logic        ds;
    logic [19:0] addr;
    logic [2:0]  ecs;
    logic [1:0]  eoe;
    logic [1:0]  ewe;
    logic [19:0] eaddr;
    logic [3:0]  elen;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'hC0, 8'h00, 1'b0, 1'b0, 20'h01234, 3'b110, 2'b10, 2'b11, 20'h01234, 4'd2}, // R2 R3 R6
    '{8'hC5, 8'h00, 1'b1, 1'b0, 20'h45678, 3'b101, 2'b11, 2'b01, 20'h45678, 4'd3}, // R3 R6
    '{8'h8E, 8'h00, 1'b1, 1'b0, 20'h8ABCD, 3'b011, 2'b11, 2'b11, 20'h8ABCD, 4'd4}, // R4
    '{8'h33, 8'h00, 1'b0, 1'b0, 20'hC0001, 3'b111, 2'b10, 2'b11, 20'h00001, 4'd6}, // R1 R5
    '{8'h50, 8'h00, 1'b0, 1'b0, 20'h80010, 3'b110, 2'b10, 2'b11, 20'hC0010, 4'd4}, // R5 R6
    '{8'hC0, 8'h03, 1'b0, 1'b1, 20'h12345, 3'b110, 2'b10, 2'b11, 20'h82345, 4'd2}, // R8
    '{8'hC0, 8'h03, 1'b0, 1'b0, 20'h12345, 3'b110, 2'b10, 2'b11, 20'h12345, 4'd2}, // R8
    '{8'hC0, 8'h10, 1'b0, 1'b0, 20'h00010, 3'b100, 2'b10, 2'b11, 20'h00010, 4'd2}, // R9
    '{8'h02, 8'h03, 1'b1, 1'b1, 20'h40000, 3'b011, 2'b11, 2'b10, 20'hD0000, 4'd7}  // R6 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_dspace = 1'b0;
  logic [19:0] req_addr = '0;
  logic        ready, done;
  logic [2:0]  cs_n;
  logic [1:0]  oe_n, we_n;
  logic [19:0] mem_addr;

  int checks = 0;
  int errors = 0;

  logic [2:0]  s_cs, s_cs_end;
  logic [1:0]  s_oe, s_we, s_oe_end, s_we_end;
  logic [19:0] s_addr;
  int          s_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbc_top u_mbc_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_write(req_write),
    .req_dspace(req_dspace), .req_addr(req_addr), .ready(ready),
    .done(done), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .mem_addr(mem_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic access(input logic wr, input logic ds, input logic [19:0] a);
    req_valid = 1'b1; req_write = wr; req_dspace = ds; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    s_cs = cs_n; s_oe = oe_n; s_we = we_n; s_addr = mem_addr;
    s_len = 1;
    while (!done && s_len < 20) begin
      @(negedge clk);
      s_len++;
    end
    s_cs_end = cs_n; s_oe_end = oe_n; s_we_end = we_n;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R7: reset state
    check("R7 cs_n", 32'(cs_n), 32'h7);
    check("R7 oe_n", 32'(oe_n), 32'h3);
    check("R7 we_n", 32'(we_n), 32'h3);
    check("R7 done", 32'(done), 32'h0);
    check("R7 mem_addr", 32'(mem_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 ready", 32'(ready), 32'h1);

    // R7 R6: reset register value means cs0, pair 0, four waits
    access(1'b0, 1'b0, 20'h00000);
    check("R7 default cs", 32'(s_cs), 32'h6);
    check("R7 default oe", 32'(s_oe), 32'h2);
    check("R6 default len", s_len, 6);

    // R11: request during an access is ignored
    req_valid = 1'b1; req_write = 1'b0; req_dspace = 1'b0; req_addr = 20'h00100;
    @(negedge clk);
    req_addr = 20'h40200;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    s_len = 3;
    while (!done && s_len < 20) begin
      @(negedge clk);
      s_len++;
    end
    check("R11 length kept", s_len, 6);
    check("R11 address kept", 32'(mem_addr), 32'h00100);
    @(negedge clk);
    check("R11 ready after", 32'(ready), 32'h1);

    for (int i = 0; i < NV; i++) begin
      wr_cfg({1'b0, VEC[i].addr[19:18]}, VEC[i].bcfg);
      wr_cfg(3'd4, VEC[i].mode);
      access(VEC[i].wr, VEC[i].ds, VEC[i].addr);
      check($sformatf("R2 cs vec%0d", i), 32'(s_cs), 32'(VEC[i].ecs));
      check($sformatf("R3 oe vec%0d", i), 32'(s_oe), 32'(VEC[i].eoe));
      check($sformatf("R3 R4 we vec%0d", i), 32'(s_we), 32'(VEC[i].ewe));
      check($sformatf("R1 R5 R8 addr vec%0d", i), 32'(s_addr), 32'(VEC[i].eaddr));
      check($sformatf("R6 len vec%0d", i), s_len, 32'(VEC[i].elen));
      check($sformatf("R10 end cs vec%0d", i), 32'(s_cs_end),
            VEC[i].mode[4] ? 32'h5 : 32'h7);
      check($sformatf("R10 end oe/we vec%0d", i), 32'({s_oe_end, s_we_end}), 32'hF);
      if (i == 7) begin
        // R9: forced chip select while idle
        check("R9 idle cs1 low", 32'(cs_n), 32'h5);
      end
    end

    // R9: clearing the mode restores an idle high chip select
    wr_cfg(3'd4, 8'h00);
    check("R9 cleared", 32'(cs_n), 32'h7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule